// File: doc/BRIEF.md
# Memory-Reference Effective Address Unit

This block resolves the effective address of a memory-reference instruction in a 12-bit accumulator machine. A caller presents the instruction word and the address it was fetched from with a one-cycle `start` pulse. The block forms a direct address from the 7-bit in-page offset. That address lies either on page zero or on the instruction's own 128-word page, depending on the page bit. If the indirect bit is clear, that address is the result. If the indirect bit is set, that address names a pointer word. The block reads the pointer over a request/acknowledge read port, and the word returned becomes the effective address.

Eight pointer locations on page zero (octal 0010 through 0017) auto-index. A pointer fetched from one of them is incremented modulo 4096. The incremented value is written back to the same location over a request/acknowledge write port, and it is also used as the effective address. An instruction that itself sits on page zero always refers to page zero, whatever its page bit says. Octal words 1410 and 1610 placed there therefore both auto-index through location 0010. Any instruction, wherever it is stored, can reach page zero by clearing its page bit.

Direct references finish one cycle after `start` and use no memory cycle. Indirect references use one read, and auto-indexing references add one write. Completion is signalled by a single-cycle `done` pulse. `ea` holds the result from the `done` cycle until the next result is written.

Top module: `mref_addr_unit`

## Requirements
- R1: After reset, `busy`, `done`, `rd_req` and `wr_req` are all low.
- R2: Field positions (numbering instruction bits 11 down to 0): bit 8 is the indirect flag, bit 7 is the page flag, and bits 6..0 are the in-page offset. Bits 11..9 never change the result.
- R3: When the page flag is 1 and the instruction address is at or above octal 0200, the pointer/direct address is the instruction address bits 11..7 followed by the offset.
- R4: When the page flag is 0, the pointer/direct address is the offset with bits 11..7 zero.
- R5: When the instruction address is below octal 0200 (page zero), the page flag is ignored and R4 applies.
- R6: A direct reference (indirect flag 0) raises `done` exactly one cycle after `start`, with `ea` equal to the direct address, and it raises neither `rd_req` nor `wr_req`.
- R7: An indirect reference holds `rd_req` high with `rd_addr` equal to the pointer address until `rd_ack`. For a pointer address outside 0010..0017, `done` follows in the next cycle with `ea` equal to the `rd_data` sampled with `rd_ack`.
- R8: For a pointer address in octal 0010..0017, the cycle after `rd_ack` raises `wr_req`. It stays high until `wr_ack`, with `wr_addr` equal to the pointer address and `wr_data` equal to the read value plus one. `done` follows in the cycle after `wr_ack`, with `ea` equal to `wr_data`.
- R9: The auto-index increment wraps, so octal 7777 becomes 0000.
- R10: A `start` pulse while `busy` is high is ignored. It does not alter the operation in progress or its result.
- R11: `rd_req` and `wr_req` are never high together, and `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin resolving the presented instruction (accepted only when not busy) |
| instr | input | 12 | Memory-reference instruction word |
| instr_addr | input | 12 | Address the instruction was fetched from |
| busy | output | 1 | An operation is in progress |
| rd_req | output | 1 | Pointer read request |
| rd_addr | output | 12 | Pointer read address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` valid with it |
| rd_data | input | 12 | Pointer word returned by memory |
| wr_req | output | 1 | Auto-index write-back request |
| wr_addr | output | 12 | Write-back address |
| wr_data | output | 12 | Incremented pointer value |
| wr_ack | input | 1 | Write acknowledge |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 12 | Effective address, valid from the `done` cycle |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that requests are mutually exclusive and that `done` is a single pulse. It checks that request addresses and write data stay stable while unacknowledged. It checks that a direct `start` completes in one cycle. It checks that an acknowledged read of an auto-index location is followed by a write of the read value plus one, and that a non-auto-index read returns the read word as `ea`.

The address arithmetic itself can only be shown by the bench's scenarios: current page versus page zero, the page flag being ignored for page-zero instructions, the bounds 0007/0010/0017/0020, and the 7777 wrap. These scenarios also cover a `start` arriving mid-operation, and the bench compares random instructions at random addresses against its own model.

// File: rtl/mref_addr_pkg.sv
package mref_addr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_DONE  = 2'd3
   } ea_state_e;

endpackage

// File: rtl/ea_field_decode.sv
module ea_field_decode #(
   parameter int WORD_W     = 12,
   parameter int AUTO_LO    = 8,
   parameter int AUTO_HI    = 15,
   parameter bit AUTO_INDEX = 1'b1
) (
   input  logic [WORD_W-4:0] ifld,
   input  logic [WORD_W-1:0] iaddr,
   output logic [WORD_W-1:0] ptr,
   output logic              is_ind,
   output logic              is_auto
);
   localparam int OFS_W   = WORD_W - 5;
   localparam int PG_W    = WORD_W - OFS_W;
   localparam int IND_POS = WORD_W - 4;
   localparam int PG_POS  = WORD_W - 5;

   logic             on_page_zero;
   logic             use_cur_page;
   logic [PG_W-1:0]  page_base;

   assign on_page_zero = (iaddr[WORD_W-1:OFS_W] == {PG_W{1'b0}});
   assign use_cur_page = ifld[PG_POS] & ~on_page_zero;
   assign page_base    = use_cur_page ? iaddr[WORD_W-1:OFS_W] : {PG_W{1'b0}};
   assign ptr          = {page_base, ifld[OFS_W-1:0]};
   assign is_ind       = ifld[IND_POS];

   generate
      if (AUTO_INDEX) begin : g_autoidx
         assign is_auto = (ptr >= WORD_W'(AUTO_LO)) && (ptr <= WORD_W'(AUTO_HI));
      end else begin : g_noautoidx
         assign is_auto = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ea_autoinc.sv
module ea_autoinc #(
   parameter int WORD_W = 12
) (
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);
   // Modulo 2**WORD_W: the carry out of the top bit is dropped.
   assign dout = din + WORD_W'(1);
endmodule

// File: rtl/ea_seq.sv
module ea_seq
   import mref_addr_pkg::*;
#(
   parameter int WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] ptr_in,
   input  logic              ind_in,
   input  logic              auto_in,
   input  logic              rd_ack,
   input  logic [WORD_W-1:0] rd_data,
   input  logic [WORD_W-1:0] rd_inc,
   input  logic              wr_ack,
   output logic              busy,
   output logic              rd_req,
   output logic              wr_req,
   output logic [WORD_W-1:0] mem_addr,
   output logic [WORD_W-1:0] wr_data,
   output logic              done,
   output logic [WORD_W-1:0] ea
);
   ea_state_e         state_q;
   logic [WORD_W-1:0] ptr_q;
   logic [WORD_W-1:0] wdat_q;
   logic [WORD_W-1:0] ea_q;
   logic              auto_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ptr_q   <= '0;
         wdat_q  <= '0;
         ea_q    <= '0;
         auto_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  ptr_q  <= ptr_in;
                  auto_q <= auto_in;
                  if (ind_in) begin
                     state_q <= ST_READ;
                  end else begin
                     ea_q    <= ptr_in;
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_READ: begin
               if (rd_ack) begin
                  if (auto_q) begin
                     wdat_q  <= rd_inc;
                     ea_q    <= rd_inc;
                     state_q <= ST_WRITE;
                  end else begin
                     ea_q    <= rd_data;
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_WRITE: begin
               if (wr_ack) state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign rd_req   = (state_q == ST_READ);
   assign wr_req   = (state_q == ST_WRITE);
   assign done     = (state_q == ST_DONE);
   assign mem_addr = ptr_q;
   assign wr_data  = wdat_q;
   assign ea       = ea_q;
endmodule

// File: rtl/mref_addr_unit.sv
module mref_addr_unit #(
   parameter int WORD_W     = 12,
   parameter int AUTO_LO    = 8,
   parameter int AUTO_HI    = 15,
   parameter bit AUTO_INDEX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] instr,
   input  logic [WORD_W-1:0] instr_addr,
   output logic              busy,
   output logic              rd_req,
   output logic [WORD_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [WORD_W-1:0] rd_data,
   output logic              wr_req,
   output logic [WORD_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data,
   input  logic              wr_ack,
   output logic              done,
   output logic [WORD_W-1:0] ea
);
   localparam int OFS_W   = WORD_W - 5;
   localparam int FLD_TOP = WORD_W - 4;

   initial begin
      if (WORD_W < 8)
         $fatal(1, "mref_addr_unit: WORD_W must be at least 8");
      if (AUTO_LO > AUTO_HI)
         $fatal(1, "mref_addr_unit: AUTO_LO exceeds AUTO_HI");
      if (AUTO_HI >= (1 << OFS_W))
         $fatal(1, "mref_addr_unit: auto-index window must lie on page zero");
   end

   // Opcode bits take no part in address formation.
   logic unused_opcode;
   assign unused_opcode = ^instr[WORD_W-1:FLD_TOP+1];

   logic [WORD_W-1:0] ptr_w;
   logic              ind_w;
   logic              auto_w;
   logic [WORD_W-1:0] inc_w;
   logic [WORD_W-1:0] mem_addr_w;

   ea_field_decode #(
      .WORD_W    (WORD_W),
      .AUTO_LO   (AUTO_LO),
      .AUTO_HI   (AUTO_HI),
      .AUTO_INDEX(AUTO_INDEX)
   ) u_decode (
      .ifld   (instr[FLD_TOP:0]),
      .iaddr  (instr_addr),
      .ptr    (ptr_w),
      .is_ind (ind_w),
      .is_auto(auto_w)
   );

   ea_autoinc #(
      .WORD_W(WORD_W)
   ) u_inc (
      .din (rd_data),
      .dout(inc_w)
   );

   ea_seq #(
      .WORD_W(WORD_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .ptr_in  (ptr_w),
      .ind_in  (ind_w),
      .auto_in (auto_w),
      .rd_ack  (rd_ack),
      .rd_data (rd_data),
      .rd_inc  (inc_w),
      .wr_ack  (wr_ack),
      .busy    (busy),
      .rd_req  (rd_req),
      .wr_req  (wr_req),
      .mem_addr(mem_addr_w),
      .wr_data (wr_data),
      .done    (done),
      .ea      (ea)
   );

   assign rd_addr = mem_addr_w;
   assign wr_addr = mem_addr_w;
endmodule

// File: rtl/mref_addr_unit_chk.sv
module mref_addr_unit_chk #(
   parameter int WORD_W  = 12,
   parameter int AUTO_LO = 8,
   parameter int AUTO_HI = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              ind_bit,
   input logic              busy,
   input logic              rd_req,
   input logic [WORD_W-1:0] rd_addr,
   input logic              rd_ack,
   input logic [WORD_W-1:0] rd_data,
   input logic              wr_req,
   input logic [WORD_W-1:0] wr_addr,
   input logic [WORD_W-1:0] wr_data,
   input logic              wr_ack,
   input logic              done,
   input logic [WORD_W-1:0] ea
);
   logic rd_in_window;
   assign rd_in_window = (rd_addr >= WORD_W'(AUTO_LO)) && (rd_addr <= WORD_W'(AUTO_HI));

   assert_req_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_direct_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !ind_bit) |=> (done && !rd_req && !wr_req));

   assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

   assert_rd_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ack && !rd_in_window) |=> (done && ea == $past(rd_data)));

   assert_wr_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ack && rd_in_window) |=>
         (wr_req && wr_data == WORD_W'($past(rd_data) + WORD_W'(1))));

   assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

   assert_wr_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> ((wr_addr >= WORD_W'(AUTO_LO)) && (wr_addr <= WORD_W'(AUTO_HI))));

   assert_wr_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wr_ack) |=> (done && ea == $past(wr_data)));
endmodule

bind mref_addr_unit mref_addr_unit_chk #(
   .WORD_W (WORD_W),
   .AUTO_LO(AUTO_LO),
   .AUTO_HI(AUTO_HI)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .ind_bit(instr[WORD_W-4]),
   .busy   (busy),
   .rd_req (rd_req),
   .rd_addr(rd_addr),
   .rd_ack (rd_ack),
   .rd_data(rd_data),
   .wr_req (wr_req),
   .wr_addr(wr_addr),
   .wr_data(wr_data),
   .wr_ack (wr_ack),
   .done   (done),
   .ea     (ea)
);

// File: tb/sim_mref_addr_unit.sv
module sim_mref_addr_unit;
   localparam int CLK_PERIOD = 10;
   localparam int WD = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [WD-1:0] instr = '0;
   logic [WD-1:0] instr_addr = '0;
   logic          busy;
   logic          rd_req;
   logic [WD-1:0] rd_addr;
   logic          rd_ack = 1'b0;
   logic [WD-1:0] rd_data = '0;
   logic          wr_req;
   logic [WD-1:0] wr_addr;
   logic [WD-1:0] wr_data;
   logic          wr_ack = 1'b0;
   logic          done;
   logic [WD-1:0] ea;

   int n_checks = 0;
   int n_fails  = 0;
   logic [WD-1:0] mem [int];

   always #(CLK_PERIOD/2) clk = ~clk;

   mref_addr_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .instr_addr(instr_addr),
      .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
      .done(done), .ea(ea)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %o expected %o", tag, what, act, exp);
      end
   endtask

   function automatic int peek(input int a);
      if (mem.exists(a)) return int'(mem[a]);
      return (a * 731 + 1234) % 4096;
   endfunction

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   // One reference: L = read-ack latency, WL = write-ack latency (cycles of waiting).
   task automatic run(input int ins, input int at, input int L, input int WL,
                      input bit poke, input string tag);
      int ofs, pbit, indf, ptr, old, exp_ea, dn;
      bit pz, autof;
      ofs   = ins % 128;
      pbit  = (ins / 128) % 2;
      indf  = (ins / 256) % 2;
      pz    = (at < 128);
      ptr   = (pbit == 1 && !pz) ? (at / 128) * 128 + ofs : ofs;
      autof = (indf == 1) && ptr >= 8 && ptr <= 15;
      old   = peek(ptr);
      exp_ea = (indf == 0) ? ptr : (autof ? (old + 1) % 4096 : old);
      dn    = (indf == 0) ? 0 : (autof ? L + WL + 2 : L + 1);

      @(negedge clk);
      check(!busy, tag, "idle before start", int'(busy), 0);
      start = 1'b1; instr = WD'(ins); instr_addr = WD'(at);
      @(negedge clk);
      for (int k = 0; k <= dn; k++) begin
         bit e_rd, e_wr, e_dn;
         rd_ack = 1'b0; wr_ack = 1'b0; start = 1'b0;
         if (poke && k == 0) begin
            start = 1'b1; instr = ~WD'(ins); instr_addr = ~WD'(at);
         end
         e_rd = (indf == 1) && k <= L;
         e_wr = autof && k >= L + 1 && k <= L + 1 + WL;
         e_dn = (k == dn);
         check(rd_req == e_rd, tag, "rd_req", int'(rd_req), int'(e_rd));
         check(wr_req == e_wr, tag, "wr_req", int'(wr_req), int'(e_wr));
         check(done == e_dn, tag, "done", int'(done), int'(e_dn));
         if (e_rd) check(int'(rd_addr) == ptr, tag, "rd_addr", int'(rd_addr), ptr);
         if (e_wr) begin
            check(int'(wr_addr) == ptr, tag, "wr_addr", int'(wr_addr), ptr);
            check(int'(wr_data) == (old + 1) % 4096, tag, "wr_data", int'(wr_data), (old + 1) % 4096);
         end
         if (e_dn) check(int'(ea) == exp_ea, tag, "ea", int'(ea), exp_ea);
         if (rd_req && k == L) begin
            rd_ack = 1'b1; rd_data = WD'(peek(int'(rd_addr)));
         end
         if (wr_req && k == L + 1 + WL) begin
            wr_ack = 1'b1; mem[int'(wr_addr)] = wr_data;
         end
         @(negedge clk);
      end
      start = 1'b0; rd_ack = 1'b0; wr_ack = 1'b0;
      check(!done && !busy, tag, "return to idle", int'(done) + 2 * int'(busy), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual expired expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs after reset
      check(!busy && !done && !rd_req && !wr_req, "R1", "reset state",
            int'({busy, done, rd_req, wr_req}), 0);

      run('o1045, 'o3000, 0, 0, 0, "R4");     // page zero, direct
      run('o1245, 'o3000, 0, 0, 0, "R3");     // current page, direct
      run('o5245, 'o3000, 0, 0, 0, "R2");     // opcode bits differ, same result
      run('o7377, 'o7600, 0, 0, 0, "R2");     // top page, offset 177
      run('o1245, 'o0100, 0, 0, 0, "R5");     // page flag ignored on page zero
      run('o1200, 'o0200, 0, 0, 0, "R6");     // first non-zero page, direct
      run('o1445, 'o3000, 0, 0, 0, "R7");     // indirect via page zero
      run('o1645, 'o3000, 2, 0, 0, "R7");     // indirect via current page, slow read
      run('o1410, 'o2000, 1, 2, 0, "R8");     // auto-index from high page
      run('o1410, 'o0100, 0, 0, 0, "R8");     // auto-index on page zero
      run('o1610, 'o0100, 0, 1, 0, "R5");     // page flag ignored: still auto-index
      run('o1610, 'o2000, 0, 0, 0, "R3");     // current page 2010: no auto-index
      run('o1407, 'o4000, 0, 0, 0, "R8");     // just below window
      run('o1420, 'o4000, 0, 0, 0, "R8");     // just above window
      run('o1417, 'o4000, 1, 1, 0, "R8");     // top of window
      mem['o17] = 12'o7777;
      run('o1417, 'o0400, 1, 0, 0, "R9");     // wrap 7777 -> 0000
      check(mem['o17] == 12'o0000, "R9", "written pointer", int'(mem['o17]), 0);
      run('o1445, 'o3000, 2, 0, 1, "R10");    // start while busy ignored
      run('o1411, 'o1000, 1, 1, 1, "R10");
      run('o1045, 'o3000, 0, 0, 1, "R10");    // start during done cycle ignored

      for (int i = 0; i < 400; i++) begin
         int ins, at;
         ins = int'($urandom % 4096);
         at  = (($urandom % 3) == 0) ? int'($urandom % 128) : int'($urandom % 4096);
         if (($urandom % 4) == 0) ins = (ins & 'o7600) | 'o10 | int'($urandom % 8);
         run(ins, at, int'($urandom % 3), int'($urandom % 3), bit'($urandom % 2), "R11");
      end

      finish_run();
   end
endmodule